// File: doc/BRIEF.md
# Descriptor-Chained Transmit DMA Channel

This block is one transmit channel of a packet DMA engine. Software builds a linked list of four-word buffer descriptors in memory, sets the channel enable, and writes the address of the first descriptor into the head register. The engine fetches each descriptor and checks that hardware owns it. It then reads the packet buffer word by word and sends the packet as a byte stream. Short frames are padded with zero bytes. When a packet is done, the engine writes the mode/status word back with the owner flag cleared.

The engine follows the next pointers until it meets a null one. It flags end-of-queue in that last descriptor and goes idle. Software can append more work by linking a new descriptor behind the tail. If end-of-queue was already flagged, software restarts the channel through the head register. Software reports the descriptors it has reclaimed through a completion-pointer register. A soft-reset bit returns the channel to its idle state.

Top module: `txdma_channel`

## Requirements
- R1: After reset the channel is idle. No memory request and no stream byte is presented. The control and status registers read zero, and `head_err` is low.
- R2: A write to the head register (address 1) while the channel is idle and enabled starts the channel. The first memory read goes to the written address, and the descriptor words are read at offsets 0, 4, 8 and 12.
- R3: The descriptor word at offset 12 is the mode word. If its bit 29 (owner) is clear, the engine streams no byte, writes nothing, and returns to idle.
- R4: The packet length is the low 11 bits of the mode word. Bytes are taken from the buffer at offset 4 in little-endian order: byte 0 comes from bits 7:0 of the first word. `tx_last` is high only on the final byte.
- R5: A packet shorter than 60 bytes is sent as 60 bytes, and the added bytes are zero.
- R6: After the last byte, the engine writes the mode word back to descriptor offset 12. In that word bit 29 is cleared, the low 11 bits hold the number of bytes sent, and bit 28 is set exactly when the next pointer is zero. All other bits keep their fetched values.
- R7: The engine follows the next pointer at offset 0. A zero next pointer ends the chain: after that write-back the channel is idle, and the head register reads the address of the last descriptor.
- R8: A head-register write while the channel is busy is ignored. It sets status bit 1 and `head_err`, and both stay set until a soft reset.
- R9: Control bit 0 enables the channel. A head write while the channel is disabled is ignored and raises no error. Clearing the enable while the channel is busy stops the chain after the descriptor in progress.
- R10: Writing 1 to control bit 1 causes a soft reset. The bit reads 1 in the cycle after the write and 0 after that. The soft reset clears the error flag and the completion pointer, and it leaves the engine idle.
- R11: The completion-pointer register (address 2) reads back the last value written to it.
- R12: While `mem_req` waits for `mem_gnt`, the request fields hold steady. While `tx_valid` waits for `tx_ready`, the byte and `tx_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 head, 2 completion, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Stream sink accepts the byte |
| head_err | output | 1 | Sticky flag: head write while busy |

## Verification
Stream bytes and memory writes are judged at the clock edge where their handshake completes. The bench evaluates each handshake half a cycle earlier, at the falling edge, using the `mem_gnt` and `tx_ready` values it has just driven for that edge. Register results are due one edge after the write strobe: busy and error status, and the soft-reset bit. The bench reads them right after the falling edge that follows the write. The soft-reset bit is read twice, once in that same half cycle and once a cycle later, to see it self-clear. The reference model builds the expected byte queue and write-back queue from its own copy of memory before each start. Any byte or write beyond those queues is reported at once as a failure.

// File: rtl/txdma_pkg.sv
// Shared constants and types of the transmit DMA channel.
// Assumes 32-bit words and byte addresses aligned to a word.
package txdma_pkg;
    localparam int WORD_W  = 32;
    localparam int BIT_SOP = 31;
    localparam int BIT_EOP = 30;
    localparam int BIT_OWN = 29;
    localparam int BIT_EOQ = 28;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_HEAD = 2'd1;
    localparam logic [1:0] RA_DONE = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_BUF_REQ,
        ST_BUF_WAIT,
        ST_SEND,
        ST_WBACK
    } eng_state_t;
endpackage

// File: rtl/txdma_regs.sv
// Register file of the channel: enable, self-clearing soft reset, head
// write decode, completion pointer and sticky busy-write error.
// Assumes at most one register write per cycle.
module txdma_regs
    import txdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] cur_ptr,
    output logic              enable,
    output logic              sreset,
    output logic              start,
    output logic [WORD_W-1:0] start_ptr,
    output logic              head_err
);
    logic              en_q;
    logic              srst_q;
    logic              err_q;
    logic [WORD_W-1:0] done_q;
    logic              wr_ctrl;
    logic              wr_head;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_head = reg_wr && (reg_addr == RA_HEAD);

    // Control bits: enable is software owned, soft reset lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            srst_q <= 1'b0;
        end else begin
            srst_q <= wr_ctrl && reg_wdata[1];
            if (wr_ctrl) en_q <= reg_wdata[0];
        end
    end

    // Completion pointer and sticky error, both cleared by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            done_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == RA_DONE)) done_q <= reg_wdata;
            if (wr_head && busy) err_q <= 1'b1;
        end
    end

    // Read mux.
    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {{(WORD_W-2){1'b0}}, srst_q, en_q};
            RA_HEAD: reg_rdata = cur_ptr;
            RA_DONE: reg_rdata = done_q;
            default: reg_rdata = {{(WORD_W-2){1'b0}}, err_q, busy};
        endcase
    end

    assign enable    = en_q;
    assign sreset    = srst_q;
    assign start     = wr_head && !busy && en_q && !srst_q;
    assign start_ptr = reg_wdata;
    assign head_err  = err_q;

    AST_BUSY_HEAD_ERR: assert property (@(posedge clk) disable iff (!rst_n || srst_q)
        (wr_head && busy) |=> head_err); // R8
    AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && !(wr_ctrl && reg_wdata[1])) |=> !srst_q); // R10
endmodule

// File: rtl/txdma_engine.sv
// Descriptor walker: fetches four-word descriptors, streams the buffer
// bytes with zero padding up to MIN_LEN, writes the mode word back and
// follows the next pointer. Assumes word-aligned descriptors and buffers,
// one outstanding memory request, and read data arriving after the grant.
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sreset,
    input  logic              enable,
    input  logic              start,
    input  logic [WORD_W-1:0] start_ptr,
    output logic              busy,
    output logic [WORD_W-1:0] cur_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    localparam int BPW   = WORD_W / 8;
    localparam int ALIGN = $clog2(BPW);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

    eng_state_t        st;
    logic [WORD_W-1:0] cur, nxt, bptr, mode, word;
    logic [1:0]        widx;
    logic [LEN_W-1:0]  cnt, cnt_inc, len, plen;
    logic              in_data;

    assign len     = mode[LEN_W-1:0];
    assign plen    = (len < MIN_L) ? MIN_L : len;
    assign cnt_inc = cnt + LEN_W'(1);
    assign in_data = cnt < len;

    // Descriptor walk and byte-stream state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || sreset) begin
            st   <= ST_IDLE;
            cur  <= '0;
            nxt  <= '0;
            bptr <= '0;
            mode <= '0;
            word <= '0;
            widx <= '0;
            cnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    cur  <= start_ptr;
                    widx <= '0;
                    st   <= ST_DESC_REQ;
                end
                ST_DESC_REQ: if (mem_gnt) st <= ST_DESC_WAIT;
                ST_DESC_WAIT: if (mem_rvalid) begin
                    case (widx)
                        2'd0:    nxt  <= mem_rdata;
                        2'd1:    bptr <= mem_rdata;
                        2'd3:    mode <= mem_rdata;
                        default: ;
                    endcase
                    if (widx == 2'd3) begin
                        cnt <= '0;
                        if (!mem_rdata[BIT_OWN])
                            st <= ST_IDLE;
                        else if (mem_rdata[LEN_W-1:0] != '0)
                            st <= ST_BUF_REQ;
                        else
                            st <= ST_SEND;
                    end else begin
                        widx <= widx + 2'd1;
                        st   <= ST_DESC_REQ;
                    end
                end
                ST_BUF_REQ: if (mem_gnt) st <= ST_BUF_WAIT;
                ST_BUF_WAIT: if (mem_rvalid) begin
                    word <= mem_rdata;
                    st   <= ST_SEND;
                end
                ST_SEND: if (tx_ready) begin
                    if (cnt == plen - LEN_W'(1)) begin
                        st <= ST_WBACK;
                    end else begin
                        cnt <= cnt_inc;
                        if ((cnt_inc[ALIGN-1:0] == '0) && (cnt_inc < len))
                            st <= ST_BUF_REQ;
                    end
                end
                ST_WBACK: if (mem_gnt) begin
                    if ((nxt == '0) || !enable) begin
                        st <= ST_IDLE;
                    end else begin
                        cur  <= nxt;
                        widx <= '0;
                        st   <= ST_DESC_REQ;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Memory request fields for the current state.
    always_comb begin
        mem_req   = (st == ST_DESC_REQ) || (st == ST_BUF_REQ) || (st == ST_WBACK);
        mem_we    = (st == ST_WBACK);
        mem_wdata = {mode[BIT_SOP], mode[BIT_EOP], 1'b0, (nxt == '0),
                     mode[BIT_EOQ-1:LEN_W], plen};
        case (st)
            ST_DESC_REQ: mem_addr = cur + (WORD_W'(widx) << ALIGN);
            ST_BUF_REQ:  mem_addr = bptr + WORD_W'({cnt[LEN_W-1:ALIGN], {ALIGN{1'b0}}});
            default:     mem_addr = cur + WORD_W'(3 * BPW);
        endcase
    end

    assign tx_valid = (st == ST_SEND);
    assign tx_data  = in_data ? word[{cnt[ALIGN-1:0], 3'b000} +: 8] : 8'h00;
    assign tx_last  = tx_valid && (cnt == plen - LEN_W'(1));
    assign busy     = (st != ST_IDLE);
    assign cur_ptr  = cur;

    AST_OWNER_GATE: assert property (@(posedge clk) disable iff (!rst_n || sreset)
        (st == ST_DESC_WAIT && mem_rvalid && widx == 2'd3 && !mem_rdata[BIT_OWN])
        |=> (st == ST_IDLE)); // R3
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || sreset)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R12
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n || sreset)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
    AST_WB_FORM: assert property (@(posedge clk) disable iff (!rst_n || sreset)
        (mem_req && mem_we) |-> (!mem_wdata[BIT_OWN] && mem_wdata[LEN_W-1:0] >= MIN_L)); // R6
endmodule

// File: rtl/txdma_channel.sv
// Top of the transmit DMA channel: register file plus descriptor engine.
// Assumes a single clock and synchronous active-low reset.
module txdma_channel
    import txdma_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int MIN_LEN = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        head_err
);
    logic              busy, enable, sreset, start;
    logic [WORD_W-1:0] cur_ptr, start_ptr;

    txdma_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .cur_ptr(cur_ptr),
        .enable(enable), .sreset(sreset), .start(start), .start_ptr(start_ptr),
        .head_err(head_err)
    );

    txdma_engine #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_engine (
        .clk(clk), .rst_n(rst_n), .sreset(sreset), .enable(enable),
        .start(start), .start_ptr(start_ptr), .busy(busy), .cur_ptr(cur_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );
endmodule

// File: tb/tb_txdma_channel.sv
module tb_txdma_channel;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last, head_err;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    txdma_channel dut (.*);

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] mem [0:511];
    logic [7:0]  exp_b [$];
    bit          exp_l [$];
    logic [31:0] wb_a [$];
    logic [31:0] wb_d [$];

    bit          pend_rd = 0;
    logic [31:0] pend_a = '0;
    bit          arm_first = 0;
    logic [31:0] first_addr = '0;
    bit          prev_stall = 0;
    logic [7:0]  prev_data = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural memory, stream sink and reference comparison.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            chk(0, "WDOG", "watchdog expired", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        mem_rvalid = pend_rd;
        if (pend_rd) mem_rdata = mem[pend_a[10:2]];
        pend_rd = 0;
        mem_gnt  = (cyc % 3) != 1;
        tx_ready = (cyc % 5) != 2;
        #1;
        if (prev_stall)   // R12 stalled byte held
            chk(tx_valid && tx_data == prev_data, "R12", "stalled byte", tx_data, prev_data);
        prev_stall = tx_valid && !tx_ready;
        prev_data  = tx_data;
        if (mem_req && arm_first) begin
            first_addr = mem_addr;
            arm_first  = 0;
        end
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                if (wb_a.size() == 0) begin
                    chk(0, "R6", "unexpected write", mem_addr, 0);
                end else begin
                    chk(mem_addr == wb_a[0], "R6", "writeback addr", mem_addr, wb_a[0]);
                    chk(mem_wdata == wb_d[0], "R6", "writeback word", mem_wdata, wb_d[0]);
                    void'(wb_a.pop_front());
                    void'(wb_d.pop_front());
                end
                mem[mem_addr[10:2]] = mem_wdata;
            end else begin
                pend_rd = 1;
                pend_a  = mem_addr;
            end
        end
        if (tx_valid && tx_ready) begin
            if (exp_b.size() == 0) begin
                chk(0, "R4", "unexpected byte", {24'h0, tx_data}, 0);
            end else begin
                chk(tx_data == exp_b[0], "R4", "byte value", {24'h0, tx_data}, {24'h0, exp_b[0]});
                chk(tx_last == exp_l[0], "R4", "last flag", {31'h0, tx_last}, {31'h0, exp_l[0]});
                void'(exp_b.pop_front());
                void'(exp_l.pop_front());
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_peek(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #2;
        v = reg_rdata;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_peek(a, v);
    endtask

    task automatic mk_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] bp,
                           input int len, input bit own);
        mem[a[10:2]]        = nx;
        mem[a[10:2] + 9'd1] = bp;
        mem[a[10:2] + 9'd2] = 32'(len);
        mem[a[10:2] + 9'd3] = {1'b1, 1'b1, own, 1'b0, 17'h0A5A5, 11'(len)};
    endtask

    // Reference walk of the chain over the bench's own memory copy.
    task automatic build_expect(input logic [31:0] head, input int maxn);
        logic [31:0] a = head;
        for (int n = 0; n < maxn; n++) begin
            logic [31:0] nx = mem[a[10:2]];
            logic [31:0] bp = mem[a[10:2] + 9'd1];
            logic [31:0] md = mem[a[10:2] + 9'd3];
            int len, plen;
            if (!md[29]) break;
            len  = int'(md[10:0]);
            plen = (len < 60) ? 60 : len;
            for (int i = 0; i < plen; i++) begin
                logic [31:0] ba = bp + 32'(i);
                logic [31:0] w = mem[ba[10:2]];
                exp_b.push_back(i < len ? 8'(w >> (8 * ba[1:0])) : 8'h00);
                exp_l.push_back(i == plen - 1);
            end
            wb_a.push_back(a + 32'd12);
            wb_d.push_back({md[31:30], 1'b0, nx == 0, md[27:11], 11'(plen)});
            if (nx == 0) break;
            a = nx;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            reg_read(2'd3, v);
            if (!v[0]) break;
        end
        chk(!v[0], "R7", "channel returns idle", v, 0);
    endtask

    task automatic chk_drained(input string req);
        chk(exp_b.size() == 0, req, "bytes left", 32'(exp_b.size()), 0);
        chk(wb_a.size() == 0, req, "writebacks left", 32'(wb_a.size()), 0);
    endtask

    initial begin
        logic [31:0] v, saved;
        for (int i = 0; i < 512; i++) mem[i] = 32'(i) * 32'h9E3779B1;
        repeat (5) @(negedge clk);
        rst_n = 1;
        #2;
        // R1 reset state
        chk(!mem_req && !tx_valid, "R1", "outputs idle", {mem_req, tx_valid}, 0);
        chk(!head_err, "R1", "head_err low", head_err, 0);
        reg_peek(2'd0, v); chk(v == 0, "R1", "control reads zero", v, 0);
        reg_peek(2'd3, v); chk(v == 0, "R1", "status reads zero", v, 0);

        // R2 R4 R5 R6 R7: three-descriptor chain
        mk_desc(32'h100, 32'h110, 32'h400, 70, 1);
        mk_desc(32'h110, 32'h120, 32'h500, 13, 1);
        mk_desc(32'h120, 32'h000, 32'h600, 64, 1);
        reg_write(2'd0, 32'h1);
        build_expect(32'h100, 99);
        chk(exp_b.size() == 70 + 60 + 64, "R5", "model padded length", 32'(exp_b.size()), 194);
        arm_first = 1;
        reg_write(2'd1, 32'h100);
        wait_idle();
        chk(first_addr == 32'h100, "R2", "first fetch at head", first_addr, 32'h100);
        chk_drained("R4");
        reg_peek(2'd1, v); chk(v == 32'h120, "R7", "head reads last descriptor", v, 32'h120);
        chk(mem[32'h12C >> 2][28], "R7", "EOQ on tail", mem[32'h12C >> 2], 0);

        // R2: append behind the tail and restart after end of queue
        mk_desc(32'h130, 32'h0, 32'h700, 60, 1);
        mem[32'h120 >> 2] = 32'h130;
        build_expect(32'h130, 99);
        reg_write(2'd1, 32'h130);
        wait_idle();
        chk_drained("R2");

        // R3: descriptor not owned by hardware
        mk_desc(32'h140, 32'h0, 32'h400, 80, 0);
        saved = mem[32'h14C >> 2];
        reg_write(2'd1, 32'h140);
        repeat (30) @(negedge clk);
        wait_idle();
        chk(mem[32'h14C >> 2] == saved, "R3", "mode word untouched", mem[32'h14C >> 2], saved);
        chk_drained("R3");

        // R8: head write while busy
        mk_desc(32'h150, 32'h0, 32'h700, 200, 1);
        mk_desc(32'h160, 32'h0, 32'h600, 61, 1);
        build_expect(32'h150, 99);
        reg_write(2'd1, 32'h150);
        repeat (3) @(negedge clk);
        reg_write(2'd1, 32'h160);
        reg_peek(2'd3, v); chk(v[1] == 1'b1, "R8", "status error bit", v, 32'h3);
        chk(head_err, "R8", "head_err set", head_err, 1);
        wait_idle();
        chk_drained("R8");
        chk(mem[32'h16C >> 2][29], "R8", "ignored descriptor still owned", mem[32'h16C >> 2], 0);
        reg_peek(2'd3, v); chk(v[1] == 1'b1, "R8", "error sticky", v, 32'h2);

        // R11: completion pointer
        reg_write(2'd2, 32'h150);
        reg_read(2'd2, v); chk(v == 32'h150, "R11", "completion readback", v, 32'h150);

        // R10: soft reset
        reg_write(2'd0, 32'h3);
        reg_peek(2'd0, v); chk(v == 32'h3, "R10", "reset bit set", v, 32'h3);
        reg_read(2'd0, v); chk(v == 32'h1, "R10", "reset bit cleared", v, 32'h1);
        reg_peek(2'd3, v); chk(v == 32'h0, "R10", "error cleared and idle", v, 0);
        reg_peek(2'd2, v); chk(v == 32'h0, "R10", "completion cleared", v, 0);

        // R9: disabled channel ignores head
        reg_write(2'd0, 32'h0);
        mk_desc(32'h170, 32'h0, 32'h500, 62, 1);
        reg_write(2'd1, 32'h170);
        reg_peek(2'd3, v); chk(v == 32'h0, "R9", "disabled stays idle", v, 0);
        repeat (100) @(negedge clk);
        chk(mem[32'h17C >> 2][29], "R9", "descriptor untouched", mem[32'h17C >> 2], 0);

        // R9: disable mid-chain stops at the descriptor boundary
        reg_write(2'd0, 32'h1);
        mk_desc(32'h180, 32'h190, 32'h400, 100, 1);
        mk_desc(32'h190, 32'h0, 32'h500, 60, 1);
        build_expect(32'h180, 1);
        reg_write(2'd1, 32'h180);
        reg_write(2'd0, 32'h0);
        wait_idle();
        repeat (20) @(negedge clk);
        chk_drained("R9");
        chk(mem[32'h19C >> 2][29], "R9", "second descriptor not taken", mem[32'h19C >> 2], 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule